// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block holds a small bank of four 16-bit registers that exchange data over a single shared bus. Each cycle a 4-bit move command may be presented together with a strobe. The command names a source register that drives the bus and a destination register that captures the bus value on the next rising clock edge. The decode is combinational and turns the packed command into two separate vectors. A one-hot drive-enable vector chooses the bus driver. A one-hot load vector chooses the register that captures.

The bus is built as a gated OR of the register outputs, so it behaves like a set of tri-state drivers without needing real high-impedance nets. When no driver is enabled, the bus reads as zero. A narrow seed port writes a value straight into one register while no move is in progress, so the bank can be given contents to shuffle. The register contents, the bus value and both control vectors are outputs, so the surrounding logic can observe them.

Top module: `xfer_bus_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four registers to zero. Reset takes priority over any move or seed write in the same cycle.
- R2: `ctrlWord[3:2]` is the source index and `ctrlWord[1:0]` is the destination index. With `xferValid` high, the destination register takes the source register's value at the next rising edge. For example, ctrlWord 4'b0110 copies register 1 into register 2.
- R3: Bit i of `busEn` (i = 0..3) is high exactly when `xferValid` is high and the source index equals i. Bits 7:4 of `busEn` are always low.
- R4: At most one bit of `busEn` is high in any cycle.
- R5: Bit m of `loadVec` is high only when `xferValid` is high and the destination index equals m. While `xferValid` is low, `loadVec` is zero and no register changes through a move.
- R6: `busOut` equals the source register's current value while a move is presented. When no `busEn` bit is high, `busOut` is zero.
- R7: A move whose source and destination are the same register leaves that register's value unchanged.
- R8: A move changes only the destination register. The other three registers keep their values.
- R9: With `seedEn` high and `xferValid` low, register `seedIdx` takes `seedData` at the next rising edge. A seed request made while `xferValid` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| xferValid | input | 1 | Presents the move command this cycle |
| ctrlWord | input | 4 | Move command: source in [3:2], destination in [1:0] |
| seedEn | input | 1 | Requests a direct write of seedData |
| seedIdx | input | 2 | Register index for the direct write |
| seedData | input | 16 | Value for the direct write |
| busOut | output | 16 | Current shared bus value |
| busEn | output | 8 | One-hot drive enables, bits 3:0 per register, 7:4 reserved low |
| loadVec | output | 4 | One-hot capture enables per register |
| regsOut | output | 64 | Register contents, register k in bits [16k+15:16k] |

## Verification
The assertions check the cycle-by-cycle invariants on every clock:
- `busEn` is one-hot or zero, and its reserved bits stay low.
- `loadVec` and the seed writes stay silent at the times they must.
- An idle bus reads zero, and an enabled driver's value appears on the bus.
- Every load captures the bus value seen one cycle earlier.
- The bank holds its contents when nothing writes.

Only the bench scenarios show the end-to-end results:
- The mapping of command bits to register indices, such as 0110 moving register 1 into register 2.
- The untouched registers keeping their values across a sweep of all sixteen commands.
- Self-moves being harmless.
- A blocked seed request.
- Reset winning over a move presented in the same cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int NUM_REGS = 4;
  localparam int DATA_W   = 16;
  localparam int EN_W     = 8;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int CTRL_W   = 2 * SEL_W;
  localparam int FLAT_W   = NUM_REGS * DATA_W;

  typedef struct packed {
    logic [EN_W-1:0]     busEn;
    logic [NUM_REGS-1:0] load;
    logic [NUM_REGS-1:0] seedWr;
  } xferStrobes_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xferValid,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              seedEn,
  input  logic [SEL_W-1:0]  seedIdx,
  output xferStrobes_t      strb
);
  logic [SEL_W-1:0]    srcIdx;
  logic [SEL_W-1:0]    dstIdx;
  logic [EN_W-1:0]     busEnV;
  logic [NUM_REGS-1:0] loadV;
  logic [NUM_REGS-1:0] seedV;

  assign srcIdx = ctrlWord[CTRL_W-1:SEL_W];
  assign dstIdx = ctrlWord[SEL_W-1:0];

  // Drive enables: live slots decode the source index, spare slots tie low.
  for (genvar i = 0; i < EN_W; i++) begin : g_en
    if (i < NUM_REGS) begin : g_live
      assign busEnV[i] = xferValid && (srcIdx == SEL_W'(i));
    end else begin : g_spare
      assign busEnV[i] = 1'b0;
    end
  end

  // Capture enables, plus seed writes that only run when no move is presented.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ld
    assign loadV[i] = xferValid && (dstIdx == SEL_W'(i));
    assign seedV[i] = seedEn && !xferValid && (seedIdx == SEL_W'(i));
  end

  assign strb = '{busEn: busEnV, load: loadV, seedWr: seedV};

  // R4: one bus driver at most
  p_single_driver_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.busEn));

  // R3: reserved enables stay low; a presented move enables its source
  p_spare_low_r3: assert property (@(posedge clk) disable iff (rst)
    strb.busEn[EN_W-1:NUM_REGS] == '0);
  p_src_driven_r3: assert property (@(posedge clk) disable iff (rst)
    xferValid |-> strb.busEn[srcIdx]);

  // R5: no capture without a presented move
  p_no_idle_load_r5: assert property (@(posedge clk) disable iff (rst)
    !xferValid |-> (strb.load == '0));

  // R9: a seed request is blocked while a move is presented
  p_seed_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    xferValid |-> (strb.seedWr == '0));
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  xferStrobes_t      strb,
  input  logic [DATA_W-1:0] seedData,
  output logic [DATA_W-1:0] busVal,
  output logic [FLAT_W-1:0] regsFlat
);
  logic [DATA_W-1:0] regQ   [NUM_REGS];
  logic [DATA_W-1:0] drvVal [NUM_REGS];

  // Gated drivers stand in for tri-state buffers on the shared bus.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_drv
    assign drvVal[i] = strb.busEn[i] ? regQ[i] : '0;
    assign regsFlat[i*DATA_W +: DATA_W] = regQ[i];
  end

  always_comb begin
    busVal = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      busVal = busVal | drvVal[k];
    end
  end

  // Each register captures the bus on a load, otherwise takes a seed write.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regQ[i] <= '0;
      end else if (strb.load[i]) begin
        regQ[i] <= busVal;
      end else if (strb.seedWr[i]) begin
        regQ[i] <= seedData;
      end
    end

    // R2: a load captures the bus value of the previous cycle
    p_load_copy_r2: assert property (@(posedge clk) disable iff (rst)
      strb.load[i] |=> (regQ[i] == $past(busVal)));

    // R6: an enabled driver puts its register on the bus
    p_bus_source_r6: assert property (@(posedge clk) disable iff (rst)
      strb.busEn[i] |-> (busVal == regQ[i]));
  end

  // R1: reset clears the bank
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (regsFlat == '0));

  // R6: an idle bus reads zero
  p_bus_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.busEn == '0) |-> (busVal == '0));

  // R5: no writer means no change
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ((strb.load == '0) && (strb.seedWr == '0)) |=> $stable(regsFlat));
endmodule

// File: rtl/xfer_bus_top.sv
module xfer_bus_top
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xferValid,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              seedEn,
  input  logic [SEL_W-1:0]  seedIdx,
  input  logic [DATA_W-1:0] seedData,
  output logic [DATA_W-1:0] busOut,
  output logic [EN_W-1:0]   busEn,
  output logic [NUM_REGS-1:0] loadVec,
  output logic [FLAT_W-1:0] regsOut
);
  xferStrobes_t strb;

  xfer_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .xferValid(xferValid),
    .ctrlWord (ctrlWord),
    .seedEn   (seedEn),
    .seedIdx  (seedIdx),
    .strb     (strb)
  );

  xfer_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .seedData(seedData),
    .busVal  (busOut),
    .regsFlat(regsOut)
  );

  assign busEn   = strb.busEn;
  assign loadVec = strb.load;
endmodule

// File: tb/xfer_bus_top_bench.sv
module xfer_bus_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xferValid = 1'b0;
  logic [3:0]  ctrlWord = '0;
  logic        seedEn = 1'b0;
  logic [1:0]  seedIdx = '0;
  logic [15:0] seedData = '0;
  logic [15:0] busOut;
  logic [7:0]  busEn;
  logic [3:0]  loadVec;
  logic [63:0] regsOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] model [4];
  logic [63:0] expQ [$];
  string       tagQ [$];

  xfer_bus_top u_xfer_bus_top (
    .clk(clk), .rst(rst), .xferValid(xferValid), .ctrlWord(ctrlWord),
    .seedEn(seedEn), .seedIdx(seedIdx), .seedData(seedData),
    .busOut(busOut), .busEn(busEn), .loadVec(loadVec), .regsOut(regsOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] packModel();
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[k*16 +: 16] = model[k];
    return v;
  endfunction

  // Driver: presents one cycle of stimulus, checks the decode, pushes the
  // expected bank contents after the coming edge.
  task automatic step(string tag, bit r, bit v, logic [3:0] cw,
                      bit se, logic [1:0] si, logic [15:0] sd);
    logic [7:0]  eEn;
    logic [3:0]  eLd;
    logic [15:0] eBus;
    @(negedge clk);
    rst = r; xferValid = v; ctrlWord = cw;
    seedEn = se; seedIdx = si; seedData = sd;
    #1;
    eEn  = v ? (8'b1 << cw[3:2]) : 8'h00;
    eLd  = v ? (4'b1 << cw[1:0]) : 4'h0;
    eBus = v ? model[cw[3:2]] : 16'h0;
    if (!r) begin
      check({tag, " R3 busEn"}, 64'(busEn), 64'(eEn));
      check({tag, " R5 loadVec"}, 64'(loadVec), 64'(eLd));
      check({tag, " R6 busOut"}, 64'(busOut), 64'(eBus));
      check({tag, " R4 onehot"}, 64'($countones(busEn) <= 1), 64'(1));
    end
    if (r) begin
      for (int k = 0; k < 4; k++) model[k] = '0;
    end else if (v) begin
      model[cw[1:0]] = eBus;
    end else if (se) begin
      model[si] = sd;
    end
    expQ.push_back(packModel());
    tagQ.push_back(tag);
  endtask

  // Monitor: compares the bank after every edge that has a pending item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        check({tagQ.pop_front(), " regs"}, regsOut, expQ.pop_front());
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = '0;
    step("R1 reset", 1, 0, 4'h0, 0, 2'd0, 16'h0);
    step("R1 reset", 1, 0, 4'h0, 0, 2'd0, 16'h0);
    step("R9 seed0", 0, 0, 4'h0, 1, 2'd0, 16'h1111);
    step("R9 seed1", 0, 0, 4'h0, 1, 2'd1, 16'hA5C3);
    step("R9 seed2", 0, 0, 4'h0, 1, 2'd2, 16'h2222);
    step("R9 seed3", 0, 0, 4'h0, 1, 2'd3, 16'hF00D);
    step("R2 move 0110", 0, 1, 4'b0110, 0, 2'd0, 16'h0);
    step("R8 after move", 0, 0, 4'h0, 0, 2'd0, 16'h0);
    step("R5 idle cw", 0, 0, 4'b1101, 0, 2'd0, 16'h0);
    step("R5 idle cw", 0, 0, 4'b0011, 0, 2'd0, 16'h0);
    step("R7 self 1111", 0, 1, 4'b1111, 0, 2'd0, 16'h0);
    step("R7 self 0000", 0, 1, 4'b0000, 0, 2'd0, 16'h0);
    step("R9 seed blocked", 0, 1, 4'b1100, 1, 2'd1, 16'hDEAD);
    step("R2 move 1100", 0, 1, 4'b1100, 0, 2'd0, 16'h0);
    step("R9 seed1 again", 0, 0, 4'h0, 1, 2'd1, 16'h7E57);
    for (int c = 0; c < 16; c++) begin
      step("R8 sweep", 0, 1, 4'(c), 0, 2'd0, 16'h0);
      step("R9 reseed", 0, 0, 4'h0, 1, 2'(c), 16'(16'h1357 * (c + 1)));
    end
    step("R1 reset over move", 1, 1, 4'b0001, 1, 2'd2, 16'hBEEF);
    step("R6 idle zero", 0, 0, 4'h0, 0, 2'd0, 16'h0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule